// File: doc/BRIEF.md
# Host Port Mailbox with Interrupt Request

This block is a two-way, one-word-per-direction mailbox between a DSP core and a host processor. A DSP write to its data address sends a word toward the host. A host write to its data address sends a word toward the DSP. Each direction has a holding register on the writer's side and an output register on the reader's side. Each side sees a flag telling it whether its outgoing slot is free and a flag telling it whether an incoming word waits.

From the host-side flags and two host-programmed enable bits, the block drives a registered, active-low interrupt request toward the host. The host polls a status byte to learn whether this device is interrupting and which source caused it. The host services the request by touching the data register behind that source. A DMA acknowledge input holds the request inactive, and reset clears the request and every flag.

Top module: `hostlink_port`

## Requirements
- R1: After reset, host_req_n is 1. On the host side the transmit-empty flag is 1, the receive-full flag is 0 and both enable bits are 0. On the DSP side the transmit-empty flag is 1 and the receive-full flag is 0. A reset applied during traffic restores all of these values.
- R2: Host address map. At 3'd0 is the control register, where bit 0 enables receive-full requests and bit 1 enables transmit-empty requests. At 3'd2 is the status register: bit 7 is 1 while the request is active, bit 1 is transmit-empty and bit 0 is receive-full, and all other bits are 0. At 3'd4 a read returns the receive word and a write sends a transmit word. Any other address reads as 0. Read data is combinational from the current address.
- R3: DSP address map. At 8'hE9 is the status register: bit 0 is receive-full (a host word waits), bit 1 is transmit-empty, and all other bits are 0. At 8'hEB a write sends a word and a read returns the word from the host. Any other address reads as 0.
- R4: When the host receive register is empty and the DSP transmit slot is empty, a DSP data write places the word in the host receive register at the next clock edge. The same edge sets host receive-full, and DSP transmit-empty stays 1.
- R5: When the host receive register is full, a DSP data write parks the word and clears DSP transmit-empty. After a host data read clears receive-full, the parked word moves across one clock later. That move sets receive-full again and sets DSP transmit-empty.
- R6: A data write from either side while that side's transmit-empty flag is 0 is ignored. The word is never delivered.
- R7: A host data read clears host receive-full at the next edge. A status or control read changes nothing.
- R8: The host-to-DSP direction behaves the same way as R4 to R7, with roles swapped. A host data write fills the DSP receive register or is parked (clearing host transmit-empty), and a DSP data read clears DSP receive-full.
- R9: The request is (receive-full AND enable bit 0) OR (transmit-empty AND enable bit 1), taken from the register values, registered once and driven active low. It therefore falls as soon as its source flag is cleared or its enable is masked, one clock after that change.
- R10: While dma_ack is sampled 1 at a clock edge, host_req_n is 1 after that edge, whatever the flags and enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low DSP reset |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_rd | input | 1 | DSP read strobe |
| dsp_addr | input | 8 | DSP register address (low byte) |
| dsp_wdata | input | DATA_W | DSP write data |
| dsp_rdata | output | DATA_W | DSP read data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| dma_ack | input | 1 | DMA acknowledge, suppresses the request |
| host_req_n | output | 1 | Active-low interrupt request to the host |

## Verification
Directed sequences walk each path of the DSP-to-host word. The bypass write into an empty receiver separates R4 from the parked path of R5. A third write into a full slot shows that R6 discards the word rather than overwriting the parked one. Enable changes, flag clears and dma_ack pulses are timed against the one-clock request delay, which separates masking from source clearing and from DMA blocking. Random traffic then mixes both directions, invalid addresses, same-cycle read-and-write collisions and mid-run resets, and compares every read and the request line with a bench model.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

  localparam int unsigned HOST_AW = 3;
  localparam int unsigned DSP_AW  = 8;

  localparam logic [HOST_AW-1:0] H_CTRL = 3'd0;
  localparam logic [HOST_AW-1:0] H_STAT = 3'd2;
  localparam logic [HOST_AW-1:0] H_DATA = 3'd4;

  localparam logic [DSP_AW-1:0] D_STAT = 8'hE9;
  localparam logic [DSP_AW-1:0] D_DATA = 8'hEB;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
  } req_en_t;

  function automatic logic req_source(logic rxdf, logic txde, req_en_t en);
    return (rxdf & en.rx_en) | (txde & en.tx_en);
  endfunction

  function automatic logic [7:0] host_status(logic req, logic txde, logic rxdf);
    return {req, 5'b00000, txde, rxdf};
  endfunction

  function automatic logic [1:0] dsp_status(logic txe, logic rxf);
    return {txe, rxf};
  endfunction

endpackage

// File: rtl/hostlink_lane.sv
module hostlink_lane #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_word,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] out_q;
  logic              full_q;
  logic              empty_q;

  logic ev_move;
  logic ev_bypass;
  logic ev_park;
  logic ev_drain;

  assign ev_move   = !full_q && !empty_q;
  assign ev_bypass = !full_q && empty_q && wr_en;
  assign ev_park   = full_q && empty_q && wr_en;
  assign ev_drain  = full_q && rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      out_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (ev_move) begin
      out_q   <= hold_q;
      full_q  <= 1'b1;
      empty_q <= 1'b1;
    end else if (ev_bypass) begin
      out_q  <= wr_data;
      full_q <= 1'b1;
    end else begin
      if (ev_park) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
      end
      if (ev_drain) full_q <= 1'b0;
    end
  end

  assign rd_word = out_q;
  assign full    = full_q;
  assign empty   = empty_q;

  assert_bypass_delivers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bypass |=> full_q && empty_q && (out_q == $past(wr_data)));

  assert_park_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_park |=> !empty_q && (hold_q == $past(wr_data)));

  assert_move_refills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_move |=> full_q && empty_q && (out_q == $past(hold_q)));

  assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !empty_q) |=> $stable(hold_q) && $stable(out_q));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drain |=> !full_q);

endmodule

// File: rtl/hostlink_req_gen.sv
module hostlink_req_gen
  import hostlink_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rxdf,
  input  logic    txde,
  input  req_en_t en,
  input  logic    dma_ack,
  output logic    req
);

  logic src_any;
  logic req_q;

  assign src_any = req_source(rxdf, txde, en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= src_any & ~dma_ack;
  end

  assign req = req_q;

  assert_dma_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !req_q);

  assert_req_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_any && !dma_ack) |=> req_q);

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !src_any |=> !req_q);

endmodule

// File: rtl/hostlink_port.sv
module hostlink_port
  import hostlink_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dsp_wr,
  input  logic               dsp_rd,
  input  logic [DSP_AW-1:0]  dsp_addr,
  input  logic [DATA_W-1:0]  dsp_wdata,
  output logic [DATA_W-1:0]  dsp_rdata,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               dma_ack,
  output logic               host_req_n
);

  localparam int unsigned PAD_HS = DATA_W - 8;
  localparam int unsigned PAD_2  = DATA_W - 2;

  logic dsp_data_wr, dsp_data_rd, host_data_wr, host_data_rd, host_ctrl_wr;

  assign dsp_data_wr  = dsp_wr  && (dsp_addr  == D_DATA);
  assign dsp_data_rd  = dsp_rd  && (dsp_addr  == D_DATA);
  assign host_data_wr = host_wr && (host_addr == H_DATA);
  assign host_data_rd = host_rd && (host_addr == H_DATA);
  assign host_ctrl_wr = host_wr && (host_addr == H_CTRL);

  logic [DATA_W-1:0] to_host_word, to_dsp_word;
  logic host_rxdf, dsp_txe, dsp_rxf, host_txde;

  hostlink_lane #(.DATA_W(DATA_W)) u_to_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dsp_data_wr),
    .wr_data (dsp_wdata),
    .rd_en   (host_data_rd),
    .rd_word (to_host_word),
    .full    (host_rxdf),
    .empty   (dsp_txe)
  );

  hostlink_lane #(.DATA_W(DATA_W)) u_to_dsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_data_wr),
    .wr_data (host_wdata),
    .rd_en   (dsp_data_rd),
    .rd_word (to_dsp_word),
    .full    (dsp_rxf),
    .empty   (host_txde)
  );

  req_en_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            en_q <= '0;
    else if (host_ctrl_wr) en_q <= req_en_t'(host_wdata[1:0]);
  end

  logic req;

  hostlink_req_gen u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxdf    (host_rxdf),
    .txde    (host_txde),
    .en      (en_q),
    .dma_ack (dma_ack),
    .req     (req)
  );

  assign host_req_n = ~req;

  always_comb begin
    unique case (host_addr)
      H_CTRL:  host_rdata = {{PAD_2{1'b0}}, en_q};
      H_STAT:  host_rdata = {{PAD_HS{1'b0}}, host_status(req, host_txde, host_rxdf)};
      H_DATA:  host_rdata = to_host_word;
      default: host_rdata = '0;
    endcase
  end

  always_comb begin
    if (dsp_addr == D_STAT)      dsp_rdata = {{PAD_2{1'b0}}, dsp_status(dsp_txe, dsp_rxf)};
    else if (dsp_addr == D_DATA) dsp_rdata = to_dsp_word;
    else                         dsp_rdata = '0;
  end

  assert_status_top_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == H_STAT) |-> (host_rdata[7] == !host_req_n));

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_ctrl_wr |=> (en_q == $past(host_wdata[1:0])));

  assert_dsp_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((dsp_addr != D_STAT) && (dsp_addr != D_DATA)) |-> (dsp_rdata == '0));

endmodule

// File: tb/hostlink_port_tb.sv
module hostlink_port_tb_top;

  localparam int unsigned W = 24;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic dsp_wr, dsp_rd, host_wr, host_rd, dma_ack;
  logic [7:0] dsp_addr;
  logic [2:0] host_addr;
  logic [W-1:0] dsp_wdata, host_wdata, dsp_rdata, host_rdata;
  logic host_req_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostlink_port #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dsp_wr(dsp_wr), .dsp_rd(dsp_rd), .dsp_addr(dsp_addr),
    .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dma_ack(dma_ack), .host_req_n(host_req_n)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct packed {
    logic [W-1:0] pend;
    logic [W-1:0] seen;
    bit           waiting;
    bit           free;
  } box_t;

  box_t up, down;
  bit [1:0] m_en;
  bit m_req;

  // Expected next state of one mailbox direction (R4..R8)
  function automatic box_t box_after(box_t b, bit put, logic [W-1:0] word, bit take);
    box_t r = b;
    if (!b.waiting && !b.free) begin
      r.seen = b.pend; r.waiting = 1; r.free = 1;
    end else if (!b.waiting && put) begin
      r.seen = word; r.waiting = 1;
    end else begin
      if (put && b.free) begin r.pend = word; r.free = 0; end
      if (take) r.waiting = 0;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_host_read(logic [2:0] a);
    case (a)
      3'd0: return W'(m_en);
      3'd2: return W'({m_req, 5'd0, down.free, up.waiting});
      3'd4: return up.seen;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_dsp_read(logic [7:0] a);
    if (a == 8'hE9) return W'({up.free, down.waiting});
    if (a == 8'hEB) return down.seen;
    return '0;
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    up = '{pend: '0, seen: '0, waiting: 0, free: 1};
    down = up;
    m_en = 0; m_req = 0;
  endtask

  task automatic step(string tag, bit dw, bit dr, logic [7:0] da, logic [W-1:0] dwd,
                      bit hw, bit hr, logic [2:0] ha, logic [W-1:0] hwd, bit dma);
    bit nreq;
    @(negedge clk);
    dsp_wr = dw; dsp_rd = dr; dsp_addr = da; dsp_wdata = dwd;
    host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hwd; dma_ack = dma;
    #1;
    check(tag, "host_req_n", W'(host_req_n), W'(!m_req));
    if (hr) check(tag, "host_rdata", host_rdata, exp_host_read(ha));
    if (dr) check(tag, "dsp_rdata", dsp_rdata, exp_dsp_read(da));
    @(posedge clk);
    nreq = ((up.waiting & m_en[0]) | (down.free & m_en[1])) & !dma;
    up   = box_after(up,   dw && da == 8'hEB, dwd, hr && ha == 3'd4);
    down = box_after(down, hw && ha == 3'd4, hwd, dr && da == 8'hEB);
    if (hw && ha == 3'd0) m_en = hwd[1:0];
    m_req = nreq;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 8'h00, '0, 0, 0, 3'd1, '0, 0);
  endtask

  task automatic hread(string tag, logic [2:0] a);
    step(tag, 0, 0, 8'h00, '0, 0, 1, a, '0, 0);
  endtask

  task automatic dread(string tag, logic [7:0] a);
    step(tag, 0, 1, a, '0, 0, 0, 3'd1, '0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    dsp_wr = 0; dsp_rd = 0; host_wr = 0; host_rd = 0; dma_ack = 0;
    dsp_addr = 0; host_addr = 0; dsp_wdata = 0; host_wdata = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

  initial begin
    rst_n = 1;
    do_reset();

    // R1 reset values
    hread("R1", 3'd2);
    hread("R1", 3'd0);
    dread("R1", 8'hE9);
    check("R1", "req_n after reset", W'(host_req_n), W'(1));

    // R3 unmapped DSP address, R2 unmapped host address
    dread("R3", 8'hE8);
    hread("R2", 3'd7);

    // R4 bypass write, then R5 park, R6 ignored third write
    step("R4", 1, 0, 8'hEB, 24'hA1A1A1, 0, 0, 3'd1, '0, 0);
    hread("R4", 3'd2);
    dread("R4", 8'hE9);
    step("R5", 1, 0, 8'hEB, 24'hB2B2B2, 0, 0, 3'd1, '0, 0);
    dread("R5", 8'hE9);
    step("R6", 1, 0, 8'hEB, 24'hC3C3C3, 0, 0, 3'd1, '0, 0);
    hread("R7", 3'd2);          // status read must not clear
    hread("R4", 3'd4);          // reads A1, clears flag
    hread("R5", 3'd2);          // flag low for one cycle
    hread("R5", 3'd2);          // parked word moved
    hread("R6", 3'd4);          // B2, not C3
    check("R6", "word kept", host_rdata, 24'hB2B2B2);
    hread("R7", 3'd2);

    // R8 host to DSP
    step("R8", 0, 0, 8'h00, '0, 1, 0, 3'd4, 24'h111111, 0);
    step("R8", 0, 0, 8'h00, '0, 1, 0, 3'd4, 24'h222222, 0);
    hread("R8", 3'd2);
    dread("R8", 8'hEB);
    dread("R8", 8'hE9);
    dread("R8", 8'hE9);
    dread("R8", 8'hEB);

    // R9 enables, masking, source clearing; R10 DMA
    step("R2", 0, 0, 8'h00, '0, 1, 0, 3'd0, 24'h000002, 0);
    hread("R2", 3'd0);
    idle("R9", 2);
    hread("R9", 3'd2);
    step("R10", 0, 0, 8'h00, '0, 0, 0, 3'd1, '0, 1);
    step("R10", 0, 0, 8'h00, '0, 0, 0, 3'd1, '0, 1);
    idle("R10", 2);
    step("R9", 0, 0, 8'h00, '0, 1, 0, 3'd0, 24'h000000, 0);
    idle("R9", 2);
    step("R9", 0, 0, 8'h00, '0, 1, 0, 3'd0, 24'h000001, 0);
    step("R9", 1, 0, 8'hEB, 24'h5A5A5A, 0, 0, 3'd1, '0, 0);
    idle("R9", 2);
    hread("R9", 3'd4);
    idle("R9", 2);

    // random traffic with mid-run resets
    void'($urandom(32'd12345));
    for (int i = 0; i < 4000; i++) begin
      bit dw, dr, hw, hr, dm;
      logic [7:0] da;
      logic [2:0] ha;
      int sel;
      if (i % 1000 == 999) begin do_reset(); hread("R1", 3'd2); continue; end
      dw = ($urandom % 3) == 0;
      dr = ($urandom % 3) == 0;
      hw = ($urandom % 4) == 0;
      hr = ($urandom % 2) == 0;
      dm = ($urandom % 10) == 0;
      sel = $urandom % 8;
      da = (sel < 4) ? 8'hEB : (sel < 7) ? 8'hE9 : 8'($urandom);
      ha = ($urandom % 6 == 0) ? 3'($urandom) : ((hw && ($urandom % 3 == 0)) ? 3'd0 : (($urandom % 2) ? 3'd4 : 3'd2));
      step("R9 random", dw, dr, da, W'($urandom), hw, hr, ha, W'($urandom), dm);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule